// File: doc/BRIEF.md
# Real-Time Clock Control and Interrupt Source

This block is the control section of a real-time clock. It keeps seconds, minutes and hours counters. A one-cycle 1 Hz tick advances them, and a clock-enable bit can hold them still. Alongside the counters it keeps a stored alarm time of minute and hour, and signals a match when a seconds rollover lands on that time.

Software drives the block through a small register bus. That bus carries a control register, a reset register, and two alarm-time registers. A write can round the running time to the nearest minute. A write can also clear the time counters or the alarm time in a single cycle.

A single interrupt line is fed by one of three sources: the alarm match, the 1 Hz tick or the 16 Hz tick. A three-bit code built from stored bits picks the source. A global enable gates the chosen source, and the result leaves the block as a registered one-cycle pulse.

Top module: `rtc_ctl`

## Requirements
- R1: After reset, every register address reads 0x00, the time reads 0:00:00 and `irq_o` is low.
- R2: While the run bit (control bit 3) is 1, a `tick_1hz_i` pulse advances the seconds by one. While the run bit is 0, ticks leave the time unchanged.
- R3: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0. Each wrap carries into the next counter, so 23:59:59 plus one tick gives 0:00:00.
- R4: A control write with bit 4 = 1 and bit 0 = 0, made while seconds are 0 to 29, clears the seconds and leaves the minutes and hours alone. In that cycle the adjust takes priority over a coincident tick.
- R5: The same adjust write, made while seconds are 30 to 59, clears the seconds and adds one minute, with the carry into hours.
- R6: An adjust write whose bit 0 (page) is 1 does not change the time. The adjust bit is never stored and always reads back as 0.
- R7: A reset-register write with bit 5 = 1 clears seconds, minutes and hours in the same cycle. This holds even while the clock is stopped, and the clear wins over a coincident tick.
- R8: A reset-register write with bit 4 = 1 clears the alarm minute (address 2) and the alarm hour (address 3) to 0.
- R9: With the alarm enable (control bit 2) set, a tick rollover whose new minute and hour equal the stored alarm time produces a one-cycle alarm match.
- R10: The source code is {reset bit 7 (1 Hz off), reset bit 6 (16 Hz off), control bit 2}. Code 111 selects the alarm match, 010 the 1 Hz tick and 100 the 16 Hz tick. Every other code gives no interrupt.
- R11: `irq_o` pulses only while the interrupt enable (control bit 7) is 1. It follows a tick by one cycle and the tick that causes an alarm match by two cycles. Setting the enables, first without and then with interrupt enable, causes no pulse.
- R12: Control reads return the interrupt enable (bit 7), run (bit 3), alarm enable (bit 2) and page (bit 0), with all other bits at 0. Reset-register reads return the two disable bits (bits 7 and 6), with all other bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 reset, 2 alarm minute, 3 alarm hour |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| tick_1hz_i | input | 1 | One-cycle 1 Hz tick |
| tick_16hz_i | input | 1 | One-cycle 16 Hz tick |
| sec_o | output | 6 | Seconds counter |
| min_o | output | 6 | Minutes counter |
| hour_o | output | 5 | Hours counter |
| irq_o | output | 1 | Registered one-cycle interrupt pulse |

## Verification
The bench aims at the adjust threshold from both sides (29/30), at the adjust at 0:59:45 that must carry into hours, and at the page-1 adjust that must do nothing. A wrong threshold or a lost carry shows up at once in the minutes or hours reading. It runs a full day of ticks to reach 23:59:59 and checks the wrap to midnight. It also puts a clear or an adjust in the same cycle as a tick; a wrong priority leaves a seconds count of 1 behind. Every one of the eight source codes is tried with both tick kinds, the enable sequence is watched for stray pulses, and the alarm pulse is checked for its exact two-cycle delay. A design that decodes an undefined code, or that gates the interrupt a cycle late, then fires where no pulse is expected.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 2'd0,
    A_RST     = 2'd1,
    A_ALM_MIN = 2'd2,
    A_ALM_HR  = 2'd3
  } reg_addr_e;

  // control register bits
  localparam int B_IRQ_EN = 7;
  localparam int B_ADJ    = 4;
  localparam int B_RUN    = 3;
  localparam int B_ALM_EN = 2;
  localparam int B_PAGE   = 0;
  // reset register bits
  localparam int B_DIS1   = 7;
  localparam int B_DIS16  = 6;
  localparam int B_CLR_T  = 5;
  localparam int B_CLR_A  = 4;
endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              irq_en_o,
  output logic              run_en_o,
  output logic              alarm_en_o,
  output logic              page_o,
  output logic              dis_1hz_o,
  output logic              dis_16hz_o,
  output logic              adj_go_o,
  output logic              clr_time_o,
  output logic              clr_alarm_o,
  output logic              alm_min_we_o,
  output logic              alm_hr_we_o
);
  logic wr_ctrl, wr_rst;

  assign wr_ctrl = wr_i && (addr_i == A_CTRL);
  assign wr_rst  = wr_i && (addr_i == A_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_o   <= 1'b0;
      run_en_o   <= 1'b0;
      alarm_en_o <= 1'b0;
      page_o     <= 1'b0;
      dis_1hz_o  <= 1'b0;
      dis_16hz_o <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        irq_en_o   <= wdata_i[B_IRQ_EN];
        run_en_o   <= wdata_i[B_RUN];
        alarm_en_o <= wdata_i[B_ALM_EN];
        page_o     <= wdata_i[B_PAGE];
      end
      if (wr_rst) begin
        dis_1hz_o  <= wdata_i[B_DIS1];
        dis_16hz_o <= wdata_i[B_DIS16];
      end
    end
  end

  // one-shot strobes, live only during the write cycle
  assign adj_go_o     = wr_ctrl && wdata_i[B_ADJ] && !wdata_i[B_PAGE];
  assign clr_time_o   = wr_rst && wdata_i[B_CLR_T];
  assign clr_alarm_o  = wr_rst && wdata_i[B_CLR_A];
  assign alm_min_we_o = wr_i && (addr_i == A_ALM_MIN);
  assign alm_hr_we_o  = wr_i && (addr_i == A_ALM_HR);
endmodule

// File: rtl/rtc_time.sv
module rtc_time #(
  parameter int SEC_MOD  = 60,
  parameter int MIN_MOD  = 60,
  parameter int HOUR_MOD = 24,
  parameter int SEC_W    = $clog2(SEC_MOD),
  parameter int MIN_W    = $clog2(MIN_MOD),
  parameter int HOUR_W   = $clog2(HOUR_MOD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_en_i,
  input  logic              adj_go_i,
  input  logic              clr_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [MIN_W-1:0]  min_o,
  output logic [HOUR_W-1:0] hour_o,
  output logic              roll_o,
  output logic [MIN_W-1:0]  min_nxt_o,
  output logic [HOUR_W-1:0] hour_nxt_o
);
  localparam logic [SEC_W-1:0]  SEC_LAST  = SEC_W'(SEC_MOD - 1);
  localparam logic [SEC_W-1:0]  SEC_HALF  = SEC_W'(SEC_MOD / 2);
  localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(MIN_MOD - 1);
  localparam logic [HOUR_W-1:0] HOUR_LAST = HOUR_W'(HOUR_MOD - 1);

  logic [SEC_W-1:0]  sec_d;
  logic [MIN_W-1:0]  min_inc;
  logic [HOUR_W-1:0] hour_inc;

  assign min_inc  = (min_o == MIN_LAST) ? '0 : min_o + 1'b1;
  assign hour_inc = (min_o != MIN_LAST) ? hour_o :
                    (hour_o == HOUR_LAST) ? '0 : hour_o + 1'b1;

  // priority: clear, then adjust, then tick
  always_comb begin
    sec_d      = sec_o;
    min_nxt_o  = min_o;
    hour_nxt_o = hour_o;
    roll_o     = 1'b0;
    if (clr_i) begin
      sec_d      = '0;
      min_nxt_o  = '0;
      hour_nxt_o = '0;
    end else if (adj_go_i) begin
      sec_d = '0;
      if (sec_o >= SEC_HALF) begin
        min_nxt_o  = min_inc;
        hour_nxt_o = hour_inc;
      end
    end else if (tick_i && run_en_i) begin
      if (sec_o == SEC_LAST) begin
        sec_d      = '0;
        roll_o     = 1'b1;
        min_nxt_o  = min_inc;
        hour_nxt_o = hour_inc;
      end else begin
        sec_d = sec_o + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_o  <= '0;
      min_o  <= '0;
      hour_o <= '0;
    end else begin
      sec_o  <= sec_d;
      min_o  <= min_nxt_o;
      hour_o <= hour_nxt_o;
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
#(
  parameter int MIN_W  = 6,
  parameter int HOUR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              min_we_i,
  input  logic              hr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic              alarm_en_i,
  input  logic              roll_i,
  input  logic [MIN_W-1:0]  min_nxt_i,
  input  logic [HOUR_W-1:0] hour_nxt_i,
  output logic [MIN_W-1:0]  alm_min_o,
  output logic [HOUR_W-1:0] alm_hr_o,
  output logic              hit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_min_o <= '0;
      alm_hr_o  <= '0;
      hit_o     <= 1'b0;
    end else begin
      if (clr_i) begin
        alm_min_o <= '0;
        alm_hr_o  <= '0;
      end else begin
        if (min_we_i) alm_min_o <= wdata_i[MIN_W-1:0];
        if (hr_we_i)  alm_hr_o  <= wdata_i[HOUR_W-1:0];
      end
      hit_o <= alarm_en_i && roll_i && (min_nxt_i == alm_min_o)
               && (hour_nxt_i == alm_hr_o);
    end
  end
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dis_1hz_i,
  input  logic dis_16hz_i,
  input  logic alarm_en_i,
  input  logic irq_en_i,
  input  logic alarm_hit_i,
  input  logic tick_1hz_i,
  input  logic tick_16hz_i,
  output logic irq_o
);
  logic src;

  always_comb begin
    unique case ({dis_1hz_i, dis_16hz_i, alarm_en_i})
      3'b111:  src = alarm_hit_i;
      3'b010:  src = tick_1hz_i;
      3'b100:  src = tick_16hz_i;
      default: src = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_en_i && src;
  end
endmodule

// File: rtl/rtc_ctl.sv
module rtc_ctl
  import rtc_pkg::*;
#(
  parameter int SEC_MOD  = 60,
  parameter int MIN_MOD  = 60,
  parameter int HOUR_MOD = 24,
  parameter int SEC_W    = $clog2(SEC_MOD),
  parameter int MIN_W    = $clog2(MIN_MOD),
  parameter int HOUR_W   = $clog2(HOUR_MOD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_1hz_i,
  input  logic              tick_16hz_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [MIN_W-1:0]  min_o,
  output logic [HOUR_W-1:0] hour_o,
  output logic              irq_o
);
  logic irq_en, run_en, alarm_en, page, dis_1hz, dis_16hz;
  logic adj_go, clr_time, clr_alarm, alm_min_we, alm_hr_we;
  logic roll, alarm_hit;
  logic [MIN_W-1:0]  min_nxt, alm_min;
  logic [HOUR_W-1:0] hour_nxt, alm_hr;

  rtc_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .irq_en_o(irq_en), .run_en_o(run_en), .alarm_en_o(alarm_en),
    .page_o(page), .dis_1hz_o(dis_1hz), .dis_16hz_o(dis_16hz),
    .adj_go_o(adj_go), .clr_time_o(clr_time), .clr_alarm_o(clr_alarm),
    .alm_min_we_o(alm_min_we), .alm_hr_we_o(alm_hr_we)
  );

  rtc_time #(
    .SEC_MOD(SEC_MOD), .MIN_MOD(MIN_MOD), .HOUR_MOD(HOUR_MOD),
    .SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W)
  ) u_time (
    .clk_i, .rst_ni, .tick_i(tick_1hz_i), .run_en_i(run_en),
    .adj_go_i(adj_go), .clr_i(clr_time),
    .sec_o, .min_o, .hour_o,
    .roll_o(roll), .min_nxt_o(min_nxt), .hour_nxt_o(hour_nxt)
  );

  rtc_alarm #(.MIN_W(MIN_W), .HOUR_W(HOUR_W)) u_alarm (
    .clk_i, .rst_ni, .min_we_i(alm_min_we), .hr_we_i(alm_hr_we),
    .wdata_i, .clr_i(clr_alarm), .alarm_en_i(alarm_en), .roll_i(roll),
    .min_nxt_i(min_nxt), .hour_nxt_i(hour_nxt),
    .alm_min_o(alm_min), .alm_hr_o(alm_hr), .hit_o(alarm_hit)
  );

  rtc_irq u_irq (
    .clk_i, .rst_ni, .dis_1hz_i(dis_1hz), .dis_16hz_i(dis_16hz),
    .alarm_en_i(alarm_en), .irq_en_i(irq_en), .alarm_hit_i(alarm_hit),
    .tick_1hz_i, .tick_16hz_i, .irq_o
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[B_IRQ_EN] = irq_en;
        rdata_o[B_RUN]    = run_en;
        rdata_o[B_ALM_EN] = alarm_en;
        rdata_o[B_PAGE]   = page;
      end
      A_RST: begin
        rdata_o[B_DIS1]  = dis_1hz;
        rdata_o[B_DIS16] = dis_16hz;
      end
      A_ALM_MIN: rdata_o[MIN_W-1:0]  = alm_min;
      A_ALM_HR:  rdata_o[HOUR_W-1:0] = alm_hr;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_ctl_chk.sv
module rtc_ctl_chk #(
  parameter int SEC_MOD  = 60,
  parameter int MIN_MOD  = 60,
  parameter int HOUR_MOD = 24,
  parameter int SEC_W    = 6,
  parameter int MIN_W    = 6,
  parameter int HOUR_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SEC_W-1:0]  sec_o,
  input logic [MIN_W-1:0]  min_o,
  input logic [HOUR_W-1:0] hour_o,
  input logic              irq_o,
  input logic              irq_en,
  input logic              run_en,
  input logic              alarm_en,
  input logic              dis_1hz,
  input logic              dis_16hz,
  input logic              adj_go,
  input logic              clr_time,
  input logic              alarm_hit
);
  localparam int HALF = SEC_MOD / 2;

  assert_time_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sec_o) < SEC_MOD && int'(min_o) < MIN_MOD && int'(hour_o) < HOUR_MOD);

  assert_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en && !adj_go && !clr_time) |=> $stable({hour_o, min_o, sec_o}));

  assert_adj_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_go && !clr_time && int'(sec_o) < HALF)
    |=> (sec_o == '0 && $stable(min_o) && $stable(hour_o)));

  assert_adj_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_go && !clr_time && int'(sec_o) >= HALF)
    |=> (sec_o == '0 && min_o != $past(min_o)));

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_time |=> (sec_o == '0 && min_o == '0 && hour_o == '0));

  assert_alarm_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_hit |-> ($past(alarm_en) && sec_o == '0));

  assert_src_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past({dis_1hz, dis_16hz, alarm_en}) inside {3'b111, 3'b010, 3'b100}));

  assert_irq_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en));
endmodule

bind rtc_ctl rtc_ctl_chk #(
  .SEC_MOD(SEC_MOD), .MIN_MOD(MIN_MOD), .HOUR_MOD(HOUR_MOD),
  .SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sec_o(sec_o), .min_o(min_o),
  .hour_o(hour_o), .irq_o(irq_o), .irq_en(irq_en), .run_en(run_en),
  .alarm_en(alarm_en), .dis_1hz(dis_1hz), .dis_16hz(dis_16hz),
  .adj_go(adj_go), .clr_time(clr_time), .alarm_hit(alarm_hit)
);

// File: tb/rtc_ctl_bench.sv
`timescale 1ns/1ps
module rtc_ctl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       tick_1hz_i = 1'b0;
  logic       tick_16hz_i = 1'b0;
  logic [5:0] sec_o;
  logic [5:0] min_o;
  logic [4:0] hour_o;
  logic       irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model
  int m_sec, m_min, m_hr, m_amin, m_ahr;
  bit m_irq_en, m_run, m_alm_en, m_page, m_d1, m_d16;

  rtc_ctl u_rtc_ctl (.*);

  always #4 clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_src(bit [2:0] code, bit hit, bit t1, bit t16);
    case (code)
      3'b111:  return hit;
      3'b010:  return t1;
      3'b100:  return t16;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit [2:0] m_code();
    return {m_d1, m_d16, m_alm_en};
  endfunction

  task automatic m_inc_min();
    if (m_min == 59) begin
      m_min = 0;
      m_hr  = (m_hr == 23) ? 0 : m_hr + 1;
    end else m_min++;
  endtask

  task automatic m_tick(output bit roll);
    roll = 1'b0;
    if (m_run) begin
      if (m_sec == 59) begin m_sec = 0; roll = 1'b1; m_inc_min(); end
      else m_sec++;
    end
  endtask

  task automatic check_time(input string req);
    check({req, " sec"}, sec_o, m_sec);
    check({req, " min"}, min_o, m_min);
    check({req, " hour"}, hour_o, m_hr);
  endtask

  task automatic rd_check(input bit [1:0] a, input int exp, input string req);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  function automatic int exp_ctrl_rd();
    return (int'(m_irq_en) << 7) | (int'(m_run) << 3) | (int'(m_alm_en) << 2) | int'(m_page);
  endfunction

  // one tick cycle plus one idle cycle; checks the tick and alarm irq slots
  task automatic step_tick(input bit t1, input bit t16, input string req);
    bit roll, hit, e1;
    tick_1hz_i  = t1;
    tick_16hz_i = t16;
    e1 = m_irq_en && exp_src(m_code(), 1'b0, t1, t16);
    roll = 1'b0;
    if (t1) m_tick(roll);
    hit = roll && m_alm_en && (m_min == m_amin) && (m_hr == m_ahr);
    @(negedge clk_i);
    tick_1hz_i  = 1'b0;
    tick_16hz_i = 1'b0;
    check({req, " R2 time"}, 0, 0);
    n_tests--;
    check_time("R2");
    check({req, " irq tick slot"}, irq_o, e1);
    @(negedge clk_i);
    check({req, " irq alarm slot"}, irq_o, m_irq_en && exp_src(m_code(), hit, 1'b0, 1'b0));
  endtask

  task automatic fast_ticks(input int n);
    bit roll;
    tick_1hz_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_1hz_i = 1'b0;
    for (int i = 0; i < n; i++) m_tick(roll);
    @(negedge clk_i);
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d, input bit t1);
    bit adj, clr, roll;
    wr_i = 1'b1; addr_i = a; wdata_i = d; tick_1hz_i = t1;
    @(negedge clk_i);
    wr_i = 1'b0; tick_1hz_i = 1'b0;
    adj = (a == 2'd0) && d[4] && !d[0];
    clr = (a == 2'd1) && d[5];
    if (clr) begin m_sec = 0; m_min = 0; m_hr = 0; end
    else if (adj) begin
      if (m_sec >= 30) m_inc_min();
      m_sec = 0;
    end else if (t1) m_tick(roll);
    case (a)
      2'd0: begin m_irq_en = d[7]; m_run = d[3]; m_alm_en = d[2]; m_page = d[0]; end
      2'd1: begin
        m_d1 = d[7]; m_d16 = d[6];
        if (d[4]) begin m_amin = 0; m_ahr = 0; end
      end
      2'd2: m_amin = int'(d[5:0]);
      default: m_ahr = int'(d[4:0]);
    endcase
    check_time("R4/R5/R7 write");
    if (!t1) check("R11 no irq on write", irq_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    m_sec = 0; m_min = 0; m_hr = 0; m_amin = 0; m_ahr = 0;
    {m_irq_en, m_run, m_alm_en, m_page, m_d1, m_d16} = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 4; a++) rd_check(2'(a), 0, "R1 reset read");
    check_time("R1");
    check("R1 irq", irq_o, 0);

    // R2 frozen, then running
    step_tick(1, 0, "R2 frozen");
    wr(2'd0, 8'h08, 0);
    repeat (5) step_tick(1, 0, "R2 run");
    check("R2 sec after 5", sec_o, 5);

    // R4 adjust low, R6 adjust reads 0
    wr(2'd0, 8'h18, 0);
    check("R4 sec cleared", sec_o, 0);
    rd_check(2'd0, 8'h08, "R6 adjust not stored");
    fast_ticks(29);
    wr(2'd0, 8'h18, 0);
    check("R4 sec 29 no carry", min_o, 0);

    // R5 adjust high
    fast_ticks(30);
    wr(2'd0, 8'h18, 0);
    check("R5 minute carried", min_o, 1);

    // R6 page 1 blocks adjust; R12 page readback
    fast_ticks(40);
    wr(2'd0, 8'h19, 0);
    check("R6 sec kept", sec_o, 40);
    rd_check(2'd0, 8'h09, "R12 ctrl readback");
    wr(2'd0, 8'h08, 0);

    // R5 carry into hours
    wr(2'd1, 8'h20, 0);
    fast_ticks(59 * 60 + 45);
    wr(2'd0, 8'h18, 0);
    check("R5 hour carry", hour_o, 1);
    check("R5 hour carry min", min_o, 0);

    // R7 clear while frozen and against a tick
    wr(2'd0, 8'h00, 0);
    step_tick(1, 0, "R2 frozen again");
    wr(2'd1, 8'h20, 0);
    check("R7 frozen clear", hour_o, 0);
    wr(2'd0, 8'h08, 0);
    fast_ticks(10);
    wr(2'd1, 8'h20, 1);
    check("R7 clear beats tick", sec_o, 0);
    fast_ticks(7);
    wr(2'd0, 8'h18, 1);
    check("R4 adjust beats tick", sec_o, 0);

    // R3 full-day wrap
    wr(2'd1, 8'h20, 0);
    fast_ticks(86399);
    check("R3 23h", hour_o, 23);
    check("R3 59m", min_o, 59);
    check("R3 59s", sec_o, 59);
    step_tick(1, 0, "R3 midnight");
    check("R3 midnight hour", hour_o, 0);

    // R9 alarm with R11 enable sequence
    wr(2'd2, 8'd1, 0);
    wr(2'd3, 8'd0, 0);
    rd_check(2'd2, 1, "R9 alarm min readback");
    wr(2'd1, 8'hE0, 0);
    rd_check(2'd1, 8'hC0, "R12 rst readback");
    wr(2'd0, 8'h0C, 0);
    wr(2'd0, 8'h8C, 0);
    fast_ticks(59);
    step_tick(1, 0, "R9 alarm fires");
    check("R9 alarm minute", min_o, 1);
    wr(2'd1, 8'hE0, 0);
    wr(2'd0, 8'h0C, 0);
    fast_ticks(59);
    step_tick(1, 0, "R11 gated alarm");

    // R8 alarm clear
    wr(2'd1, 8'hD0, 0);
    rd_check(2'd2, 0, "R8 alarm min cleared");
    rd_check(2'd3, 0, "R8 alarm hour cleared");

    // R10 every source code with both ticks
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, (c[0] ? 8'h8C : 8'h88), 0);
      wr(2'd1, {c[2], c[1], 6'b0}, 0);
      step_tick(1, 0, "R10 code t1");
      step_tick(0, 1, "R10 code t16");
      step_tick(1, 1, "R10 code both");
    end

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        5: wr(2'd0, 8'($urandom) & 8'h9D, 0);
        6: wr(2'd1, {2'($urandom), ($urandom_range(0, 7) == 0), 1'($urandom), 4'b0}, 0);
        7: wr(2'd2, 8'((m_min + $urandom_range(0, 2)) % 60), 0);
        8: wr(2'd3, 8'(m_hr), 0);
        default: step_tick(1'($urandom), 1'($urandom), "R10 random");
      endcase
      if (op == 5) rd_check(2'd0, exp_ctrl_rd(), "R12 random ctrl read");
      if (op == 7) rd_check(2'd2, m_amin, "R9 random alarm read");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule